// File: doc/BRIEF.md
# Paged Switch Register Window Sequencer

This engine sits on the host side of a management bus. It reads registers inside an Ethernet switch whose register space is split into pages. The switch exposes a small window of management registers at one fixed PHY address. Reaching a switch register takes several bus accesses in order:

1. Select the page, which is skipped when that page is already selected.
2. Write the register offset together with a read opcode.
3. Poll the same control register until the opcode bits clear, waiting a fixed time between polls.
4. Read one or two data registers.

A caller gives a page, an offset and a width (16 or 32 bits), then pulses start. The engine returns a single-cycle done pulse, an error flag that is valid with done, and the assembled result. The management side is a simple request/response port. The engine holds a request until the responder raises ready, and read data is taken in the cycle of acceptance.

Top module: `swreg_window_seq`

## Requirements
- R1: Every management request carries PHY address 0x1E.
- R2: Page selection is a write of register 0x10 with data {page, 8'h01}. It is issued only when the requested page differs from the page last selected. After reset no page counts as selected, so the first access always selects its page, page 0xFF included.
- R3: Each access issues a write of register 0x11 with data {offset, 8'h02}, after any page selection. Writes go only to registers 0x10 and 0x11.
- R4: Completion is polled by reading register 0x11 until bits 1:0 read zero; other bits are ignored. Consecutive polls are at least GAP_US microseconds apart: 1000 cycles at the default 100 MHz and 10 us.
- R5: At most MAX_POLLS (5) polls are made. If the last one still reads busy, the access ends with done and error set, no data register is read, and the result is zero.
- R6: A 16-bit access reads register 0x18 and returns {16'h0000, data}.
- R7: A 32-bit access reads register 0x18 for bits 15:0 and then register 0x19 for bits 31:16.
- R8: A start is taken only while cmd_ready is high; a start while busy has no effect. Done lasts one cycle, error is high only with done, and no request is made while idle.
- R9: A failed access still leaves its page selected, so a following access to the same page skips page selection.
- R10: A request that is not yet accepted keeps valid, register number, direction and write data unchanged.
- R11: Reset makes cmd_ready high and holds mgmt_valid and rsp_done low; reset in mid-access abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start strobe, taken when cmd_ready is high |
| cmd_page | input | 8 | Switch register page |
| cmd_offset | input | 8 | Register offset within the page |
| cmd_wide | input | 1 | 1 selects a 32-bit read, 0 a 16-bit read |
| cmd_ready | output | 1 | Engine idle and able to take a start |
| mgmt_valid | output | 1 | Management request valid |
| mgmt_ready | input | 1 | Responder accepts the request this cycle |
| mgmt_write | output | 1 | 1 for write, 0 for read |
| mgmt_phy | output | 5 | PHY address of the request |
| mgmt_reg | output | 5 | Register number of the request |
| mgmt_wdata | output | 16 | Write data |
| mgmt_rdata | input | 16 | Read data, valid while a read is accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Completion timed out; valid with rsp_done |
| rsp_data | output | 32 | Read result, held until the next start |

## Verification
The assertions assume the responder answers each read in the cycle it raises ready. They also assume it returns data only for accepted requests, and that cmd_start never needs to be held to be seen.

The bench responder raises ready only after seeing valid, after a latency of zero to two cycles. It logs a transaction only after the acceptance edge. Its busy replies alternate between the two opcode bits and carry junk in the upper byte, so the poll decision is always made on bits 1:0 alone.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

    localparam logic [4:0]  WIN_PHY_ADDR = 5'h1E;
    localparam logic [4:0]  REG_PAGE_SEL = 5'h10;
    localparam logic [4:0]  REG_CTRL     = 5'h11;
    localparam logic [4:0]  REG_DATA_LO  = 5'h18;
    localparam logic [4:0]  REG_DATA_HI  = 5'h19;
    localparam logic [7:0]  PAGE_ENABLE  = 8'h01;
    localparam logic [7:0]  OPC_READ     = 8'h02;
    localparam logic [7:0]  PAGE_INVALID = 8'hFF;
    localparam logic [1:0]  BUSY_MASK    = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PAGE,
        S_CTRL,
        S_POLL,
        S_GAP,
        S_DLO,
        S_DHI,
        S_FIN
    } seq_state_t;

    typedef struct packed {
        logic [7:0] page;
        logic [7:0] offset;
        logic       wide;
    } win_cmd_t;

    typedef struct packed {
        logic        valid;
        logic        write;
        logic [4:0]  regnum;
        logic [15:0] wdata;
    } mgmt_req_t;

    function automatic logic [15:0] page_word(input logic [7:0] pg);
        return {pg, PAGE_ENABLE};
    endfunction

    function automatic logic [15:0] ctrl_word(input logic [7:0] off);
        return {off, OPC_READ};
    endfunction

    function automatic logic still_busy(input logic [15:0] status);
        return |(status[1:0] & BUSY_MASK);
    endfunction

endpackage

// File: rtl/swreg_gap_timer.sv
module swreg_gap_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/swreg_page_cache.sv
module swreg_page_cache
    import swreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_page,
    input  logic [7:0] probe_page,
    output logic       hit
);
    logic [7:0] cur_q;
    logic       known_q;

    // The invalid page value alone cannot stand for "nothing selected",
    // because 0xFF is a legal page; the flag carries that meaning.
    assign hit = known_q && (cur_q == probe_page);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= PAGE_INVALID;
            known_q <= 1'b0;
        end else if (load) begin
            cur_q   <= load_page;
            known_q <= 1'b1;
        end
    end
endmodule

// File: rtl/swreg_result_asm.sv
module swreg_result_asm #(
    parameter int unsigned DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            load_lo,
    input  logic            load_hi,
    input  logic [DW-1:0]   word,
    output logic [2*DW-1:0] result
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic          ld;
        logic [DW-1:0] q;

        assign ld = (h == 0) ? load_lo : load_hi;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                q <= '0;
            end else if (ld) begin
                q <= word;
            end
        end

        assign result[h*DW +: DW] = q;
    end
endmodule

// File: rtl/swreg_window_seq.sv
module swreg_window_seq
    import swreg_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned GAP_US    = 10,
    parameter int unsigned MAX_POLLS = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_start,
    input  logic [7:0]  cmd_page,
    input  logic [7:0]  cmd_offset,
    input  logic        cmd_wide,
    output logic        cmd_ready,
    output logic        mgmt_valid,
    input  logic        mgmt_ready,
    output logic        mgmt_write,
    output logic [4:0]  mgmt_phy,
    output logic [4:0]  mgmt_reg,
    output logic [15:0] mgmt_wdata,
    input  logic [15:0] mgmt_rdata,
    output logic        rsp_done,
    output logic        rsp_error,
    output logic [31:0] rsp_data
);
    localparam int unsigned RAW_GAP = (CLK_HZ / 1_000_000) * GAP_US;
    localparam int unsigned GAP_CYC = (RAW_GAP > 0) ? RAW_GAP : 1;
    localparam int unsigned PW      = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

    seq_state_t    state_q, state_d;
    win_cmd_t      cmd_q;
    logic [PW-1:0] polls_q, polls_d;
    logic          err_q, err_d;
    mgmt_req_t     req;
    logic          accept;
    logic          bus_acc;
    logic          page_hit;
    logic          gap_done;
    logic          ld_page;
    logic          ld_lo;
    logic          ld_hi;

    assign accept  = cmd_start && (state_q == S_IDLE);
    assign bus_acc = req.valid && mgmt_ready;
    assign ld_page = (state_q == S_PAGE) && bus_acc;
    assign ld_lo   = (state_q == S_DLO) && bus_acc;
    assign ld_hi   = (state_q == S_DHI) && bus_acc;

    swreg_page_cache u_cache (
        .clk        (clk),
        .rst        (rst),
        .load       (ld_page),
        .load_page  (cmd_q.page),
        .probe_page (cmd_page),
        .hit        (page_hit)
    );

    swreg_gap_timer #(.CYCLES(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == S_GAP),
        .expired (gap_done)
    );

    swreg_result_asm #(.DW(16)) u_asm (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .load_lo (ld_lo),
        .load_hi (ld_hi),
        .word    (mgmt_rdata),
        .result  (rsp_data)
    );

    // Request is a pure function of state and the latched command, so it
    // cannot change while the responder stalls.
    always_comb begin
        req        = '0;
        req.regnum = REG_CTRL;
        unique case (state_q)
            S_PAGE: begin
                req.valid  = 1'b1;
                req.write  = 1'b1;
                req.regnum = REG_PAGE_SEL;
                req.wdata  = page_word(cmd_q.page);
            end
            S_CTRL: begin
                req.valid  = 1'b1;
                req.write  = 1'b1;
                req.regnum = REG_CTRL;
                req.wdata  = ctrl_word(cmd_q.offset);
            end
            S_POLL: begin
                req.valid  = 1'b1;
                req.regnum = REG_CTRL;
            end
            S_DLO: begin
                req.valid  = 1'b1;
                req.regnum = REG_DATA_LO;
            end
            S_DHI: begin
                req.valid  = 1'b1;
                req.regnum = REG_DATA_HI;
            end
            default: req = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        polls_d = polls_q;
        err_d   = err_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    polls_d = '0;
                    err_d   = 1'b0;
                    state_d = page_hit ? S_CTRL : S_PAGE;
                end
            end
            S_PAGE: if (bus_acc) state_d = S_CTRL;
            S_CTRL: if (bus_acc) state_d = S_POLL;
            S_POLL: begin
                if (bus_acc) begin
                    if (!still_busy(mgmt_rdata)) begin
                        state_d = S_DLO;
                    end else if (polls_q == LAST_POLL) begin
                        err_d   = 1'b1;
                        state_d = S_FIN;
                    end else begin
                        polls_d = polls_q + 1'b1;
                        state_d = S_GAP;
                    end
                end
            end
            S_GAP: if (gap_done) state_d = S_POLL;
            S_DLO: if (bus_acc) state_d = cmd_q.wide ? S_DHI : S_FIN;
            S_DHI: if (bus_acc) state_d = S_FIN;
            S_FIN: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            polls_q <= '0;
            err_q   <= 1'b0;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            polls_q <= polls_d;
            err_q   <= err_d;
            if (accept) begin
                cmd_q.page   <= cmd_page;
                cmd_q.offset <= cmd_offset;
                cmd_q.wide   <= cmd_wide;
            end
        end
    end

    assign cmd_ready  = (state_q == S_IDLE);
    assign mgmt_valid = req.valid;
    assign mgmt_write = req.write;
    assign mgmt_phy   = WIN_PHY_ADDR;
    assign mgmt_reg   = req.regnum;
    assign mgmt_wdata = req.wdata;
    assign rsp_done   = (state_q == S_FIN);
    assign rsp_error  = rsp_done && err_q;
endmodule

// File: rtl/swreg_window_chk.sv
module swreg_window_chk #(
    parameter int unsigned MAX_POLLS = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_start,
    input logic        cmd_ready,
    input logic        mgmt_valid,
    input logic        mgmt_ready,
    input logic        mgmt_write,
    input logic [4:0]  mgmt_reg,
    input logic [15:0] mgmt_wdata,
    input logic        rsp_done,
    input logic        rsp_error,
    input logic [31:0] rsp_data
);
    int unsigned poll_cnt;

    always_ff @(posedge clk) begin
        if (rst || (cmd_start && cmd_ready)) begin
            poll_cnt <= 0;
        end else if (mgmt_valid && mgmt_ready && !mgmt_write && mgmt_reg == 5'h11) begin
            poll_cnt <= poll_cnt + 1;
        end
    end

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !mgmt_valid); // R8
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        cmd_start && cmd_ready |=> !cmd_ready); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R8
    AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        rsp_error |-> rsp_done); // R8
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_error |-> rsp_data == 32'h0); // R5
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        poll_cnt <= MAX_POLLS); // R5
    AST_SETUP_WRITES: assert property (@(posedge clk) disable iff (rst)
        mgmt_valid && mgmt_write |-> (mgmt_reg == 5'h10 || mgmt_reg == 5'h11)); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mgmt_valid && !mgmt_ready |=> mgmt_valid && $stable(mgmt_reg)
            && $stable(mgmt_write) && $stable(mgmt_wdata)); // R10
endmodule

bind swreg_window_seq swreg_window_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cmd_ready  (cmd_ready),
    .mgmt_valid (mgmt_valid),
    .mgmt_ready (mgmt_ready),
    .mgmt_write (mgmt_write),
    .mgmt_reg   (mgmt_reg),
    .mgmt_wdata (mgmt_wdata),
    .rsp_done   (rsp_done),
    .rsp_error  (rsp_error),
    .rsp_data   (rsp_data)
);

// File: tb/tb_swreg_window_seq.sv
module tb_swreg_window_seq;
    localparam longint GAP = 1000;
    localparam int     NV  = 8;
    // {page, offset, wide, busy polls, latency, lo, hi}
    localparam logic [53:0] VEC [NV] = '{
        {8'h01, 8'h00, 1'b0, 3'd0, 2'd0, 16'h1234, 16'h0000},  // R2 first access
        {8'h01, 8'h08, 1'b0, 3'd2, 2'd1, 16'hBEEF, 16'h0000},  // R2 skip, R4
        {8'h01, 8'h04, 1'b1, 3'd1, 2'd2, 16'hAAAA, 16'h5555},  // R7
        {8'h02, 8'h10, 1'b1, 3'd0, 2'd0, 16'h0F0F, 16'hF00D},  // R7 new page
        {8'h03, 8'h20, 1'b0, 3'd5, 2'd1, 16'h7777, 16'h0000},  // R5 timeout
        {8'h03, 8'h22, 1'b0, 3'd4, 2'd0, 16'h4321, 16'h0000},  // R9, R4 last poll ok
        {8'h01, 8'h00, 1'b1, 3'd0, 2'd2, 16'h0001, 16'h8000},  // R7
        {8'hFF, 8'h3C, 1'b0, 3'd0, 2'd1, 16'hC0DE, 16'h0000}   // R6 page FF
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_start;
    logic [7:0]  cmd_page;
    logic [7:0]  cmd_offset;
    logic        cmd_wide;
    logic        cmd_ready;
    logic        mgmt_valid;
    logic        mgmt_ready;
    logic        mgmt_write;
    logic [4:0]  mgmt_phy;
    logic [4:0]  mgmt_reg;
    logic [15:0] mgmt_wdata;
    logic [15:0] mgmt_rdata;
    logic        rsp_done;
    logic        rsp_error;
    logic [31:0] rsp_data;

    always #5 clk = ~clk;

    swreg_window_seq dut (.*);

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;

    // responder state
    int          lat_sel = 0, lat_cnt = 0, busy_left = 0;
    logic [15:0] lo_val = '0, hi_val = '0;
    logic [4:0]  cap_phy, cap_reg;
    logic        cap_wr;
    logic [15:0] cap_wd;
    logic [4:0]  lg_phy [64];
    logic [4:0]  lg_reg [64];
    logic        lg_wr  [64];
    logic [15:0] lg_wd  [64];
    int          lg_n = 0;
    longint      last_poll = -1, min_gap = 1 << 30;
    int          done_cnt = 0;

    // cache model
    logic        m_known = 1'b0;
    logic [7:0]  m_page  = 8'h00;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rsp_done) done_cnt <= done_cnt + 1;
        if (cyc == 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            mgmt_ready = 1'b0;
            lat_cnt    = 0;
        end else if (mgmt_ready) begin
            if (lg_n < 64) begin
                lg_phy[lg_n] = cap_phy;
                lg_reg[lg_n] = cap_reg;
                lg_wr[lg_n]  = cap_wr;
                lg_wd[lg_n]  = cap_wd;
            end
            lg_n       = lg_n + 1;
            mgmt_ready = 1'b0;
            lat_cnt    = 0;
        end else if (mgmt_valid) begin
            if (lat_cnt >= lat_sel) begin
                cap_phy    = mgmt_phy;
                cap_reg    = mgmt_reg;
                cap_wr     = mgmt_write;
                cap_wd     = mgmt_wdata;
                mgmt_ready = 1'b1;
                mgmt_rdata = 16'hDEAD;
                if (!mgmt_write) begin
                    case (mgmt_reg)
                        5'h11: begin
                            if (last_poll >= 0 && (cyc - last_poll) < min_gap)
                                min_gap = cyc - last_poll;
                            last_poll = cyc;
                            if (busy_left > 0) begin
                                mgmt_rdata = busy_left[0] ? 16'hAB01 : 16'hAB02;
                                busy_left  = busy_left - 1;
                            end else begin
                                mgmt_rdata = 16'hAB00;
                            end
                        end
                        5'h18:   mgmt_rdata = lo_val;
                        5'h19:   mgmt_rdata = hi_val;
                        default: mgmt_rdata = 16'hDEAD;
                    endcase
                end
            end else begin
                lat_cnt = lat_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [7:0] pg, input logic [7:0] off, input logic wide,
                           input int busy, input int lat, input logic [15:0] lo,
                           input logic [15:0] hi, input int extra_at);
        logic        exp_err, pw, got, e;
        logic [31:0] d, exp_d;
        int          npolls, n, bad;
        logic [4:0]  x_reg [16];
        logic        x_wr  [16];
        logic [15:0] x_wd  [16];

        exp_err = (busy >= 5);
        npolls  = exp_err ? 5 : busy + 1;
        pw      = !(m_known && m_page == pg);
        exp_d   = exp_err ? 32'h0 : (wide ? {hi, lo} : {16'h0000, lo});

        n = 0;
        if (pw) begin x_reg[n] = 5'h10; x_wr[n] = 1'b1; x_wd[n] = {pg, 8'h01}; n++; end
        x_reg[n] = 5'h11; x_wr[n] = 1'b1; x_wd[n] = {off, 8'h02}; n++;
        for (int p = 0; p < npolls; p++) begin
            x_reg[n] = 5'h11; x_wr[n] = 1'b0; x_wd[n] = 16'h0; n++;
        end
        if (!exp_err) begin
            x_reg[n] = 5'h18; x_wr[n] = 1'b0; x_wd[n] = 16'h0; n++;
            if (wide) begin x_reg[n] = 5'h19; x_wr[n] = 1'b0; x_wd[n] = 16'h0; n++; end
        end

        @(negedge clk);
        lg_n = 0; last_poll = -1; min_gap = 1 << 30;
        busy_left = busy; lat_sel = lat; lo_val = lo; hi_val = hi;
        cmd_page = pg; cmd_offset = off; cmd_wide = wide; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;

        got = 1'b0; d = '0; e = 1'b0;
        for (int i = 0; i < 20000 && !got; i++) begin
            if (i == extra_at) begin
                cmd_page = pg ^ 8'h0F; cmd_start = 1'b1;
            end else begin
                cmd_start = 1'b0;
            end
            if (rsp_done) begin
                got = 1'b1; d = rsp_data; e = rsp_error;
            end else begin
                @(negedge clk);
            end
        end
        cmd_start = 1'b0;
        chk(got, "R8", "done seen", got, 1);
        m_known = 1'b1; m_page = pg;

        chk(e == exp_err, "R5", "error flag", e, exp_err);
        chk(d == exp_d, wide ? "R7" : "R6", "result", d, exp_d);

        @(negedge clk);
        chk(!rsp_done && cmd_ready, "R8", "done one cycle", rsp_done, 0);

        bad = (lg_n != n) ? 1 : 0;
        for (int k = 0; k < n && k < lg_n; k++) begin
            if (lg_phy[k] != 5'h1E || lg_reg[k] != x_reg[k] || lg_wr[k] != x_wr[k] ||
                (x_wr[k] && lg_wd[k] != x_wd[k])) bad++;
        end
        chk(bad == 0, pw ? "R2" : "R3", "transaction log count", lg_n, n);
        if (lg_n > 0)
            chk(lg_phy[0] == 5'h1E, "R1", "phy address", lg_phy[0], 5'h1E);
        if (npolls > 1)
            chk(min_gap >= GAP, "R4", "poll spacing", min_gap, GAP);
    endtask

    initial begin
        rst = 1'b1; cmd_start = 1'b0; cmd_page = '0; cmd_offset = '0; cmd_wide = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_ready && !mgmt_valid && !rsp_done, "R11", "reset outputs",
            {cmd_ready, mgmt_valid, rsp_done}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !mgmt_valid, "R11", "idle after reset", {cmd_ready, mgmt_valid}, 2'b10);

        for (int v = 0; v < NV; v++) begin
            run_cmd(VEC[v][53:46], VEC[v][45:38], VEC[v][37], int'(VEC[v][36:34]),
                    int'(VEC[v][33:32]), VEC[v][31:16], VEC[v][15:0], -1);
        end

        // R8: start while busy has no effect, no request while idle
        run_cmd(8'h05, 8'h01, 1'b0, 1, 1, 16'h5A5A, 16'h0, 2);
        lg_n = 0;
        begin
            int dc0;
            dc0 = done_cnt;
            repeat (30) @(negedge clk);
            chk(lg_n == 0 && done_cnt == dc0, "R8", "busy start ignored", lg_n, 0);
        end

        // R11: reset mid-access abandons it and forgets the page
        @(negedge clk);
        busy_left = 3; lat_sel = 0; lg_n = 0;
        cmd_page = 8'h05; cmd_offset = 8'h02; cmd_wide = 1'b0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (1500) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(cmd_ready && !mgmt_valid && !rsp_done, "R11", "reset mid-access",
            {cmd_ready, mgmt_valid, rsp_done}, 3'b100);
        rst = 1'b0; m_known = 1'b0;
        // R2: same page again needs a fresh page write after reset
        run_cmd(8'h05, 8'h06, 1'b1, 0, 0, 16'h1111, 16'h2222, -1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule